// File: doc/BRIEF.md
# Tiled Conversion Address Planner

This block breaks one large image conversion into a grid of smaller tiles, so that each piece fits a resizer whose output is capped at 1024 pixels per side. It takes the input and output frame sizes, the bytes per pixel of each frame and the two buffer base addresses. It picks how many stripes to cut each dimension into, checks that the job is legal, and then walks the grid one tile at a time. For every tile it presents a descriptor: the tile's input and output width and height, the input and output DMA start addresses, and the full-frame strides.

A pulse on `start` captures the job. One cycle later the block either flags `cfg_err` or raises `desc_valid` with tile 0. The consumer pulses `tile_ack` when the current tile has finished. The next descriptor then appears in the following cycle, so a consumer that keeps `tile_ack` high converts tiles back to back. After the last tile is acknowledged, `done` pulses and the block goes idle.

Top module: `tile_plan_top`

## Requirements
- R1: Each dimension uses 1 stripe when the output size along it is at most 1024, 2 stripes when it is 1025 to 2048, and 4 stripes above 2048. The output tile size is the output dimension divided by the stripe count, rounded down. `tile_idx` equals row*stripes_w + col, so the index advances along a row first.
- R2: The input frame is cut into the same stripe counts as the output frame, and the input tile size is the input dimension divided by that count, rounded down.
- R3: `in_stride` equals in_w*in_bpp and `out_stride` equals out_w*out_bpp, the whole-frame values. They stay constant for every tile of a job.
- R4: The tile at stripe (row, col) starts at base + row*tile_h*stride + col*tile_w*bpp, for the input and the output separately.
- R5: Any of the four frame dimensions below 128 or above 4096 sets `cfg_err`. No descriptor and no `done` are then produced.
- R6: A base address that is not a multiple of 8, or a zero bytes-per-pixel value, sets `cfg_err`. The same holds when a dimension has more than one stripe and its column step (tile_w*bpp) or row step (tile_h*stride) is not a multiple of 8. Every tile address handed out is therefore 8-byte aligned.
- R7: `start` sampled at an idle clock edge makes the verdict (`desc_valid` or `cfg_err`) visible after the next edge. A `tile_ack` sampled with `desc_valid` high shows the next tile's descriptor after that same edge, and without `tile_ack` the descriptor holds.
- R8: The edge that samples `tile_ack` on the last tile drops `desc_valid` and raises `done` for exactly one cycle. While the block is busy, `start` and all configuration inputs are ignored.
- R9: After reset, `desc_valid`, `done`, `cfg_err` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture a new job when idle |
| in_w | input | 13 | Input frame width in pixels |
| in_h | input | 13 | Input frame height in lines |
| out_w | input | 13 | Output frame width in pixels |
| out_h | input | 13 | Output frame height in lines |
| in_bpp | input | 3 | Input bytes per pixel |
| out_bpp | input | 3 | Output bytes per pixel |
| in_base | input | 32 | Input buffer base address |
| out_base | input | 32 | Output buffer base address |
| tile_ack | input | 1 | Current tile has completed |
| busy | output | 1 | Job being checked or sequenced |
| desc_valid | output | 1 | Tile descriptor is valid |
| tile_idx | output | 4 | Row-major tile index |
| tile_in_w | output | 13 | Input tile width |
| tile_in_h | output | 13 | Input tile height |
| tile_out_w | output | 13 | Output tile width |
| tile_out_h | output | 13 | Output tile height |
| in_addr | output | 32 | Input tile DMA start address |
| out_addr | output | 32 | Output tile DMA start address |
| in_stride | output | 32 | Input full-frame stride in bytes |
| out_stride | output | 32 | Output full-frame stride in bytes |
| cfg_err | output | 1 | Job rejected |
| done | output | 1 | One-cycle pulse after the last tile |

## Verification
The bench sweeps output sizes that sit right at and just past the 1024 and 2048 stripe thresholds. A design with an off-by-one in the stripe choice would then produce a tile count and tile sizes that differ from the bench's arithmetic. Widths that divide into odd byte steps are mixed in, so a design that skipped the step alignment check would hand out unaligned addresses instead of raising `cfg_err`. Sizes of 127 and 4097 probe the range bounds. Each job walks every tile and compares both addresses against the closed-form offset, which catches a row wrap that forgets to move down by a whole stripe of the full-frame stride. Some jobs stall `tile_ack` and some pulse `start` with a different base mid-job, to expose a descriptor that drifts or a job that restarts.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int DIM_W  = 13;
    localparam int BPP_W  = 3;
    localparam int ADDR_W = 32;
    localparam int SH_W   = 2;
    localparam int IDX_W  = 2 * SH_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2
    } tp_state_e;

    typedef struct packed {
        logic [DIM_W-1:0]  in_w;
        logic [DIM_W-1:0]  in_h;
        logic [DIM_W-1:0]  out_w;
        logic [DIM_W-1:0]  out_h;
        logic [BPP_W-1:0]  bpp_i;
        logic [BPP_W-1:0]  bpp_o;
        logic [ADDR_W-1:0] base_i;
        logic [ADDR_W-1:0] base_o;
    } tp_job_t;

    typedef struct packed {
        tp_state_e         st;
        tp_job_t           job;
        logic [SH_W-1:0]   col;
        logic [SH_W-1:0]   row;
        logic [ADDR_W-1:0] row_i;
        logic [ADDR_W-1:0] addr_i;
        logic [ADDR_W-1:0] row_o;
        logic [ADDR_W-1:0] addr_o;
        logic              err;
        logic              done;
    } tp_regs_t;
endpackage

// File: rtl/tp_stripe_sel.sv
module tp_stripe_sel #(
    parameter int DIM_W = 13,
    parameter int LIMIT = 1024,
    parameter int SH_W  = 2
) (
    input  logic [DIM_W-1:0] dim,
    output logic [SH_W-1:0]  sh
);
    localparam logic [DIM_W-1:0] ONE_LIM = DIM_W'(LIMIT);
    localparam logic [DIM_W-1:0] TWO_LIM = DIM_W'(2 * LIMIT);

    always_comb begin
        if (dim <= ONE_LIM)      sh = SH_W'(0);
        else if (dim <= TWO_LIM) sh = SH_W'(1);
        else                     sh = SH_W'(2);
    end
endmodule

// File: rtl/tp_cfg_check.sv
module tp_cfg_check #(
    parameter int DIM_W   = 13,
    parameter int BPP_W   = 3,
    parameter int ADDR_W  = 32,
    parameter int SH_W    = 2,
    parameter int MIN_DIM = 128,
    parameter int MAX_DIM = 4096,
    parameter int ALIGN   = 8
) (
    input  logic [DIM_W-1:0]  dims [4],
    input  logic [BPP_W-1:0]  bpp_i,
    input  logic [BPP_W-1:0]  bpp_o,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] base_o,
    input  logic [ADDR_W-1:0] cstep_i,
    input  logic [ADDR_W-1:0] cstep_o,
    input  logic [ADDR_W-1:0] rstep_i,
    input  logic [ADDR_W-1:0] rstep_o,
    input  logic [SH_W-1:0]   sh_w,
    input  logic [SH_W-1:0]   sh_h,
    output logic              bad
);
    localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(ALIGN - 1);
    localparam logic [DIM_W-1:0]  LO    = DIM_W'(MIN_DIM);
    localparam logic [DIM_W-1:0]  HI    = DIM_W'(MAX_DIM);

    logic [3:0] dim_bad;

    for (genvar g = 0; g < 4; g++) begin : g_rng
        assign dim_bad[g] = (dims[g] < LO) || (dims[g] > HI);
    end

    logic col_bad, row_bad, base_bad;
    assign base_bad = (|(base_i & AMASK)) || (|(base_o & AMASK));
    assign col_bad  = (sh_w != '0) && ((|(cstep_i & AMASK)) || (|(cstep_o & AMASK)));
    assign row_bad  = (sh_h != '0) && ((|(rstep_i & AMASK)) || (|(rstep_o & AMASK)));

    assign bad = (|dim_bad) || base_bad || col_bad || row_bad
                 || (bpp_i == '0) || (bpp_o == '0);
endmodule

// File: rtl/tile_plan_top.sv
module tile_plan_top
    import tp_pkg::*;
#(
    parameter int OUT_LIMIT = 1024,
    parameter int MIN_DIM   = 128,
    parameter int MAX_DIM   = 4096,
    parameter int ALIGN     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  in_w,
    input  logic [DIM_W-1:0]  in_h,
    input  logic [DIM_W-1:0]  out_w,
    input  logic [DIM_W-1:0]  out_h,
    input  logic [BPP_W-1:0]  in_bpp,
    input  logic [BPP_W-1:0]  out_bpp,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [ADDR_W-1:0] out_base,
    input  logic              tile_ack,
    output logic              busy,
    output logic              desc_valid,
    output logic [IDX_W-1:0]  tile_idx,
    output logic [DIM_W-1:0]  tile_in_w,
    output logic [DIM_W-1:0]  tile_in_h,
    output logic [DIM_W-1:0]  tile_out_w,
    output logic [DIM_W-1:0]  tile_out_h,
    output logic [ADDR_W-1:0] in_addr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] in_stride,
    output logic [ADDR_W-1:0] out_stride,
    output logic              cfg_err,
    output logic              done
);
    tp_regs_t r_q, r_d;

    // stripe choice follows the output frame; input shares it
    logic [SH_W-1:0] sh_w, sh_h;

    tp_stripe_sel #(.DIM_W(DIM_W), .LIMIT(OUT_LIMIT), .SH_W(SH_W)) u_sel_w (
        .dim (r_q.job.out_w),
        .sh  (sh_w)
    );
    tp_stripe_sel #(.DIM_W(DIM_W), .LIMIT(OUT_LIMIT), .SH_W(SH_W)) u_sel_h (
        .dim (r_q.job.out_h),
        .sh  (sh_h)
    );

    logic [DIM_W-1:0]  tw_i, th_i, tw_o, th_o;
    logic [ADDR_W-1:0] stride_i, stride_o;
    logic [ADDR_W-1:0] cstep_i, cstep_o, rstep_i, rstep_o;

    always_comb begin
        tw_i     = r_q.job.in_w  >> sh_w;
        th_i     = r_q.job.in_h  >> sh_h;
        tw_o     = r_q.job.out_w >> sh_w;
        th_o     = r_q.job.out_h >> sh_h;
        stride_i = ADDR_W'(r_q.job.in_w)  * ADDR_W'(r_q.job.bpp_i);
        stride_o = ADDR_W'(r_q.job.out_w) * ADDR_W'(r_q.job.bpp_o);
        cstep_i  = ADDR_W'(tw_i) * ADDR_W'(r_q.job.bpp_i);
        cstep_o  = ADDR_W'(tw_o) * ADDR_W'(r_q.job.bpp_o);
        rstep_i  = ADDR_W'(th_i) * stride_i;
        rstep_o  = ADDR_W'(th_o) * stride_o;
    end

    logic [DIM_W-1:0] dims [4];
    assign dims[0] = r_q.job.in_w;
    assign dims[1] = r_q.job.in_h;
    assign dims[2] = r_q.job.out_w;
    assign dims[3] = r_q.job.out_h;

    logic job_bad;

    tp_cfg_check #(
        .DIM_W(DIM_W), .BPP_W(BPP_W), .ADDR_W(ADDR_W), .SH_W(SH_W),
        .MIN_DIM(MIN_DIM), .MAX_DIM(MAX_DIM), .ALIGN(ALIGN)
    ) u_chk (
        .dims    (dims),
        .bpp_i   (r_q.job.bpp_i),
        .bpp_o   (r_q.job.bpp_o),
        .base_i  (r_q.job.base_i),
        .base_o  (r_q.job.base_o),
        .cstep_i (cstep_i),
        .cstep_o (cstep_o),
        .rstep_i (rstep_i),
        .rstep_o (rstep_o),
        .sh_w    (sh_w),
        .sh_h    (sh_h),
        .bad     (job_bad)
    );

    logic [SH_W:0] ncol, nrow;
    logic          col_last, row_last, tile_last;

    always_comb begin
        ncol      = (SH_W+1)'(1) << sh_w;
        nrow      = (SH_W+1)'(1) << sh_h;
        col_last  = ({1'b0, r_q.col} == ncol - 1'b1);
        row_last  = ({1'b0, r_q.row} == nrow - 1'b1);
        tile_last = col_last && row_last;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.job.in_w   = in_w;
                    r_d.job.in_h   = in_h;
                    r_d.job.out_w  = out_w;
                    r_d.job.out_h  = out_h;
                    r_d.job.bpp_i  = in_bpp;
                    r_d.job.bpp_o  = out_bpp;
                    r_d.job.base_i = in_base;
                    r_d.job.base_o = out_base;
                    r_d.err        = 1'b0;
                    r_d.st         = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (job_bad) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.col    = '0;
                    r_d.row    = '0;
                    r_d.row_i  = r_q.job.base_i;
                    r_d.addr_i = r_q.job.base_i;
                    r_d.row_o  = r_q.job.base_o;
                    r_d.addr_o = r_q.job.base_o;
                    r_d.st     = ST_RUN;
                end
            end
            ST_RUN: begin
                if (tile_ack) begin
                    if (tile_last) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (col_last) begin
                        r_d.col    = '0;
                        r_d.row    = r_q.row + 1'b1;
                        r_d.row_i  = r_q.row_i + rstep_i;
                        r_d.addr_i = r_q.row_i + rstep_i;
                        r_d.row_o  = r_q.row_o + rstep_o;
                        r_d.addr_o = r_q.row_o + rstep_o;
                    end else begin
                        r_d.col    = r_q.col + 1'b1;
                        r_d.addr_i = r_q.addr_i + cstep_i;
                        r_d.addr_o = r_q.addr_o + cstep_o;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign desc_valid = (r_q.st == ST_RUN);
    assign tile_idx   = IDX_W'((IDX_W'(r_q.row) << sh_w) + IDX_W'(r_q.col));
    assign tile_in_w  = tw_i;
    assign tile_in_h  = th_i;
    assign tile_out_w = tw_o;
    assign tile_out_h = th_o;
    assign in_addr    = r_q.addr_i;
    assign out_addr   = r_q.addr_o;
    assign in_stride  = stride_i;
    assign out_stride = stride_o;
    assign cfg_err    = r_q.err;
    assign done       = r_q.done;

    // R8: completion flag lasts one cycle and leaves the block idle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!desc_valid && !busy));
    // R5: a rejected job never shows a descriptor
    a_r5_err_no_desc: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !desc_valid);
    // R6: every handed-out address is aligned
    a_r6_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> ((in_addr % ALIGN) == 0 && (out_addr % ALIGN) == 0));
    // R7: acknowledged non-final tile moves to the next index
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && tile_ack && !tile_last)
        |=> (desc_valid && tile_idx == $past(tile_idx) + 1'b1));
    // R7: descriptor holds without an acknowledge
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !tile_ack) |=> ($stable(in_addr) && $stable(out_addr)));
    // R3: strides constant across a job
    a_r3_stride_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && $past(desc_valid)) |-> ($stable(in_stride) && $stable(out_stride)));
endmodule

// File: tb/tile_plan_top_bench.sv
module tile_plan_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] in_w = '0, in_h = '0, out_w = '0, out_h = '0;
    logic [2:0]  in_bpp = '0, out_bpp = '0;
    logic [31:0] in_base = '0, out_base = '0;
    logic        tile_ack = 1'b0;
    logic        busy, desc_valid, cfg_err, done;
    logic [3:0]  tile_idx;
    logic [12:0] tile_in_w, tile_in_h, tile_out_w, tile_out_h;
    logic [31:0] in_addr, out_addr, in_stride, out_stride;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tile_plan_top u_tile_plan_top (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h),
        .in_bpp(in_bpp), .out_bpp(out_bpp),
        .in_base(in_base), .out_base(out_base),
        .tile_ack(tile_ack), .busy(busy), .desc_valid(desc_valid),
        .tile_idx(tile_idx), .tile_in_w(tile_in_w), .tile_in_h(tile_in_h),
        .tile_out_w(tile_out_w), .tile_out_h(tile_out_h),
        .in_addr(in_addr), .out_addr(out_addr),
        .in_stride(in_stride), .out_stride(out_stride),
        .cfg_err(cfg_err), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    function automatic int stripes(input int d);
        if (d <= 1024) return 1;
        if (d <= 2048) return 2;
        return 4;
    endfunction

    task automatic run_job(input int iw, input int ih, input int ow, input int oh,
                           input int bi, input int bo, input int ib, input int ob,
                           input bit gap);
        int sw, sh, tiw, tih, tow, toh, sti, sto;
        bit eerr;
        sw  = stripes(ow);
        sh  = stripes(oh);
        tiw = iw / sw; tih = ih / sh; tow = ow / sw; toh = oh / sh;
        sti = iw * bi; sto = ow * bo;
        eerr = 0;
        if (iw < 128 || iw > 4096 || ih < 128 || ih > 4096) eerr = 1;
        if (ow < 128 || ow > 4096 || oh < 128 || oh > 4096) eerr = 1;
        if (bi == 0 || bo == 0) eerr = 1;
        if ((ib % 8) != 0 || (ob % 8) != 0) eerr = 1;
        if (sw > 1 && (((tiw * bi) % 8) != 0 || ((tow * bo) % 8) != 0)) eerr = 1;
        if (sh > 1 && (((tih * sti) % 8) != 0 || ((toh * sto) % 8) != 0)) eerr = 1;

        @(negedge clk);
        in_w = 13'(iw); in_h = 13'(ih); out_w = 13'(ow); out_h = 13'(oh);
        in_bpp = 3'(bi); out_bpp = 3'(bo); in_base = 32'(ib); out_base = 32'(ob);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        if (eerr) begin
            chk(cfg_err && !desc_valid, "R5/R6 reject",
                $sformatf("err=%0d dv=%0d", cfg_err, desc_valid), "err=1 dv=0");
            @(negedge clk);
            chk(!done && !desc_valid && !busy, "R5 no done after reject",
                $sformatf("done=%0d dv=%0d busy=%0d", done, desc_valid, busy), "0 0 0");
            return;
        end
        chk(!cfg_err && desc_valid, "R7 first descriptor timing",
            $sformatf("err=%0d dv=%0d", cfg_err, desc_valid), "err=0 dv=1");
        chk(in_stride == 32'(sti) && out_stride == 32'(sto), "R3 strides",
            $sformatf("%0d/%0d", in_stride, out_stride), $sformatf("%0d/%0d", sti, sto));
        for (int r = 0; r < sh; r++) begin
            for (int c = 0; c < sw; c++) begin
                longint ea, eb;
                ea = longint'(ib) + longint'(r) * tih * sti + longint'(c) * tiw * bi;
                eb = longint'(ob) + longint'(r) * toh * sto + longint'(c) * tow * bo;
                chk(desc_valid && tile_idx == 4'(r * sw + c), "R1 tile index",
                    $sformatf("%0d", tile_idx), $sformatf("%0d", r * sw + c));
                chk(tile_out_w == 13'(tow) && tile_out_h == 13'(toh), "R1 output tile size",
                    $sformatf("%0dx%0d", tile_out_w, tile_out_h), $sformatf("%0dx%0d", tow, toh));
                chk(tile_in_w == 13'(tiw) && tile_in_h == 13'(tih), "R2 input tile size",
                    $sformatf("%0dx%0d", tile_in_w, tile_in_h), $sformatf("%0dx%0d", tiw, tih));
                chk(in_addr == 32'(ea) && out_addr == 32'(eb), "R4 tile addresses",
                    $sformatf("%h/%h", in_addr, out_addr), $sformatf("%h/%h", 32'(ea), 32'(eb)));
                chk(in_stride == 32'(sti) && out_stride == 32'(sto), "R3 stride per tile",
                    $sformatf("%0d/%0d", in_stride, out_stride), $sformatf("%0d/%0d", sti, sto));
                if (r == 0 && c == 0) begin
                    // R8: new start and new config while busy must be ignored
                    tile_ack = 1'b0;
                    start = 1'b1;
                    in_base = in_base + 32'h40;
                    out_w = 13'd200;
                    @(negedge clk);
                    start = 1'b0;
                    chk(desc_valid && tile_idx == 4'd0 && in_addr == 32'(ib)
                        && tile_out_w == 13'(tow), "R8 start ignored while busy",
                        $sformatf("idx=%0d a=%h w=%0d", tile_idx, in_addr, tile_out_w),
                        $sformatf("idx=0 a=%h w=%0d", ib, tow));
                end
                if (gap) begin
                    tile_ack = 1'b0;
                    @(negedge clk);
                    chk(desc_valid && in_addr == 32'(ea) && out_addr == 32'(eb), "R7 hold without ack",
                        $sformatf("%h/%h", in_addr, out_addr), $sformatf("%h/%h", 32'(ea), 32'(eb)));
                end
                tile_ack = 1'b1;
                @(negedge clk);
            end
        end
        tile_ack = 1'b0;
        chk(done && !desc_valid, "R8 done after last ack",
            $sformatf("done=%0d dv=%0d", done, desc_valid), "done=1 dv=0");
        @(negedge clk);
        chk(!done && !busy, "R8 done single cycle",
            $sformatf("done=%0d busy=%0d", done, busy), "done=0 busy=0");
    endtask

    initial begin
        int ows [6] = '{600, 1024, 1032, 2048, 2064, 4096};
        int ohs [5] = '{128, 1024, 1040, 2048, 4096};
        int bps [3] = '{1, 2, 4};
        repeat (3) @(negedge clk);
        chk(!desc_valid && !done && !cfg_err && !busy, "R9 reset state",
            $sformatf("%0d%0d%0d%0d", desc_valid, done, cfg_err, busy), "0000");
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 5; b++)
                for (int k = 0; k < 3; k++)
                    run_job(ows[a] / 2, ohs[b] / 2, ows[a], ohs[b], bps[k], bps[2 - k],
                            32'h1000_0000, 32'h2000_0008, (a + b + k) % 2 == 1);
        // range bounds
        run_job(127, 400, 800, 600, 2, 2, 32'h100, 32'h200, 0);
        run_job(400, 400, 4097, 600, 2, 2, 32'h100, 32'h200, 0);
        run_job(4096, 4096, 4096, 4096, 4, 4, 32'h0, 32'h0100_0000, 0);
        run_job(128, 128, 128, 128, 1, 1, 32'h8, 32'h10, 1);
        // alignment and bpp
        run_job(512, 512, 1024, 1024, 2, 2, 32'h104, 32'h200, 0);
        run_job(512, 512, 1024, 1024, 2, 2, 32'h100, 32'h203, 0);
        run_job(512, 512, 1024, 1024, 0, 2, 32'h100, 32'h200, 0);
        run_job(1030, 300, 2060, 600, 1, 1, 32'h100, 32'h200, 0);
        run_job(1031, 300, 1000, 600, 3, 3, 32'h100, 32'h200, 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule